// File: doc/BRIEF.md
# Blanking-Start / Scrambler-Reset Symbol Selector

This block sits in a serial link's symbol path and decides, slot by slot, which control code goes out. It issues one of three codes for each slot: ordinary data, a blanking-start (BS) marker, or a scrambler-reset (SR) marker.

A BS event happens in either of two cases. The upstream framer can request one on a slot. The block also raises one by itself when no video is active and a programmable number of slots has passed without a BS. Every BS event is then emitted as BS or replaced by SR. A programmable swap count sets how many plain BS symbols pass between two SR symbols. A count of zero turns every BS into SR, and the usual setting is 0x1FF. Idle BS spacing is typically 0x2000 slots in normal running and 0xFC slots during compliance testing.

For fast link resumption, a one-shot path can be armed with a single-cycle start pulse. Once armed, it counts BS events up to a loaded count. The BS event after that is forced to SR once, and the block then carries on with its periodic swapping.

The slot input and the symbol output are valid/ready streams. An input slot is taken only when `slot_valid` and `slot_ready` are both high. `slot_ready` is high whenever the output register is empty or is being drained in the same cycle. While `sym_valid` is high and `sym_ready` is low, the output code is held, and no counter moves. Control fields and the start pulse are plain pins, sampled on every clock.

Top module: `bs_sr_swapper`

## Requirements
- R1: With swap count N, the BS events since the last SR are emitted as BS (code 1) while fewer than N have passed. The next BS event is emitted as SR (code 2). Every SR clears the periodic count, so the sequence is N BS symbols followed by one SR.
- R2: With swap count 0, every BS event is emitted as SR.
- R3: While `video_active` is 0, an accepted slot becomes a BS event when it is the K-th accepted slot since the last BS event, where K is `idle_interval`. An interval of 0 behaves as 1. While `video_active` is 1, the idle count is held at zero.
- R4: An accepted slot with `slot_bs` = 1 is a BS event, whatever the value of `video_active`.
- R5: A one-cycle `load_start` pulse sets `oneshot_armed` to 1 on the next cycle and clears the one-shot count. With load count L, the BS event that follows L counted BS events while armed is emitted as SR, and `oneshot_armed` then returns to 0.
- R6: After the one-shot SR, periodic swapping resumes with its count restarted from zero at that SR.
- R7: When the one-shot and the periodic swap fall due on the same BS event, one SR is emitted, and both the one-shot and the periodic count are finished by it.
- R8: Accepted slots that are not BS events are emitted as data (code 0). Code 3 is never emitted.
- R9: While `sym_valid` = 1 and `sym_ready` = 0, `slot_ready` is 0 and `sym_code` holds its value. Slots presented during the stall advance no counter.
- R10: After reset, `sym_valid` = 0, `oneshot_armed` = 0, `slot_ready` = 1, and all counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| video_active | input | 1 | High while a video stream occupies the link |
| slot_valid | input | 1 | Input slot present |
| slot_ready | output | 1 | Input slot can be accepted |
| slot_bs | input | 1 | Framer requests a BS on this slot |
| swap_count | input | CNT_W (9) | BS symbols between SR substitutions |
| idle_interval | input | IDLE_W (16) | Idle BS spacing in slots |
| load_count | input | LOAD_W (8) | BS events counted before the one-shot SR |
| load_start | input | 1 | Single-cycle arm pulse for the one-shot |
| sym_valid | output | 1 | Output symbol present |
| sym_ready | input | 1 | Downstream takes the symbol |
| sym_code | output | 2 | 0 data, 1 BS, 2 SR |
| oneshot_armed | output | 1 | One-shot waiting to fire |

## Verification
The bench builds the block with its default widths: a 9-bit swap count, a 16-bit idle interval and an 8-bit load count. It then programs small field values (swap counts of 0 to 4, idle intervals of 0 and 3, load counts of 1 and 2), so that swap cycles, idle insertion and one-shot firing all show up within a few slots. The full 0x1FF swap count is also run across 512 BS events to reach the top of the periodic counter. Stall windows with `sym_ready` held low show that unaccepted slots leave the counts untouched.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    SYM_DATA = 2'd0,
    SYM_BS   = 2'd1,
    SYM_SR   = 2'd2
  } sym_code_e;
endpackage

// File: rtl/bsr_idle_gen.sv
module bsr_idle_gen #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              video_active,
  input  logic              bs_req,
  input  logic [IDLE_W-1:0] interval,
  output logic              bs_evt
);
  localparam logic [IDLE_W:0] ONE = {{IDLE_W{1'b0}}, 1'b1};

  logic [IDLE_W-1:0] idle_cnt;
  logic [IDLE_W:0]   cnt_next;
  logic              idle_due;

  always_comb begin
    cnt_next = {1'b0, idle_cnt} + ONE;
    idle_due = !video_active && (cnt_next >= {1'b0, interval});
    bs_evt   = bs_req || idle_due;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (step) begin
      if (video_active || bs_evt) idle_cnt <= '0;
      else                        idle_cnt <= cnt_next[IDLE_W-1:0];
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    video_active && step |=> idle_cnt == '0);
endmodule

// File: rtl/bsr_swap_ctl.sv
module bsr_swap_ctl #(
  parameter int CNT_W  = 9,
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [CNT_W-1:0]  swap_count,
  input  logic [LOAD_W-1:0] load_count,
  input  logic              load_start,
  output logic              make_sr,
  output logic              armed
);
  localparam logic [CNT_W-1:0]  C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [LOAD_W-1:0] L_ONE = {{(LOAD_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]  bs_cnt;
  logic [LOAD_W-1:0] os_cnt;
  logic              per_due;
  logic              os_due;

  always_comb begin
    per_due = bs_cnt >= swap_count;
    os_due  = armed && (os_cnt >= load_count);
    make_sr = per_due || os_due;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bs_cnt <= '0;
    end else if (step) begin
      bs_cnt <= make_sr ? '0 : bs_cnt + C_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      os_cnt <= '0;
    end else if (load_start) begin
      armed  <= 1'b1;
      os_cnt <= '0;
    end else if (step && armed) begin
      if (os_due) armed  <= 1'b0;
      else        os_cnt <= os_cnt + L_ONE;
    end
  end

  // R5
  arm_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> armed);

  // R5
  disarm_only_on_bs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(step));

  // R2
  zero_count_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && swap_count == '0 |-> make_sr);
endmodule

// File: rtl/bsr_out_stage.sv
module bsr_out_stage
  import bsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  sym_code_e in_code,
  output logic      in_ready,
  output logic      out_valid,
  output sym_code_e out_code,
  input  logic      out_ready
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= SYM_DATA;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_code <= in_code;
    end
  end

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code));

  // R8
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_code != 2'd3);
endmodule

// File: rtl/bs_sr_swapper.sv
module bs_sr_swapper
  import bsr_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int IDLE_W = 16,
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              video_active,
  input  logic              slot_valid,
  output logic              slot_ready,
  input  logic              slot_bs,
  input  logic [CNT_W-1:0]  swap_count,
  input  logic [IDLE_W-1:0] idle_interval,
  input  logic [LOAD_W-1:0] load_count,
  input  logic              load_start,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic [1:0]        sym_code,
  output logic              oneshot_armed
);
  logic      accept;
  logic      bs_evt;
  logic      make_sr;
  sym_code_e next_code;
  sym_code_e out_code;

  assign accept = slot_valid && slot_ready;

  bsr_idle_gen #(.IDLE_W(IDLE_W)) u_idle (
    .clk          (clk),
    .rst_n        (rst_n),
    .step         (accept),
    .video_active (video_active),
    .bs_req       (slot_bs),
    .interval     (idle_interval),
    .bs_evt       (bs_evt)
  );

  bsr_swap_ctl #(.CNT_W(CNT_W), .LOAD_W(LOAD_W)) u_swap (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (accept && bs_evt),
    .swap_count (swap_count),
    .load_count (load_count),
    .load_start (load_start),
    .make_sr    (make_sr),
    .armed      (oneshot_armed)
  );

  always_comb begin
    if (!bs_evt)      next_code = SYM_DATA;
    else if (make_sr) next_code = SYM_SR;
    else              next_code = SYM_BS;
  end

  bsr_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (slot_valid),
    .in_code   (next_code),
    .in_ready  (slot_ready),
    .out_valid (sym_valid),
    .out_code  (out_code),
    .out_ready (sym_ready)
  );

  assign sym_code = out_code;

  // R9
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && !sym_ready |-> !slot_ready);

  // R4
  request_gives_bs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && slot_bs |=> sym_valid && sym_code != 2'd0);
endmodule

// File: tb/test_bs_sr_swapper.sv
module test_bs_sr_swapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        video_active = 1'b1;
  logic        slot_valid = 1'b0;
  logic        slot_ready;
  logic        slot_bs = 1'b0;
  logic [8:0]  swap_count = 9'd2;
  logic [15:0] idle_interval = 16'd3;
  logic [7:0]  load_count = 8'd0;
  logic        load_start = 1'b0;
  logic        sym_valid;
  logic        sym_ready = 1'b1;
  logic [1:0]  sym_code;
  logic        oneshot_armed;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bs_sr_swapper i_bs_sr_swapper (
    .clk(clk), .rst_n(rst_n), .video_active(video_active),
    .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_bs(slot_bs),
    .swap_count(swap_count), .idle_interval(idle_interval),
    .load_count(load_count), .load_start(load_start),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_code(sym_code),
    .oneshot_armed(oneshot_armed)
  );

  // {video_active, slot_bs, expected code}; swap count 2, idle interval 3
  localparam logic [3:0] VEC [0:13] = '{
    4'b1000, 4'b1101, 4'b1101, 4'b1110, 4'b1000, 4'b0000, 4'b0000,
    4'b0001, 4'b0101, 4'b0000, 4'b0000, 4'b0010, 4'b1000, 4'b0000
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    slot_valid = 1'b0;
    load_start = 1'b0;
    sym_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic slot(input logic act, input logic bs);
    video_active = act;
    slot_bs = bs;
    slot_valid = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0;
  endtask

  task automatic pulse_start();
    load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10 reset state
    chk("R10 sym_valid", sym_valid, 0);
    chk("R10 armed", oneshot_armed, 0);
    chk("R10 slot_ready", slot_ready, 1);

    // Table: R1 R3 R4 R8
    foreach (VEC[i]) begin
      slot(VEC[i][3], VEC[i][2]);
      chk($sformatf("R1/R3/R4/R8 vec %0d", i), sym_code, VEC[i][1:0]);
      chk("R8 valid", sym_valid, 1);
    end

    // R2: zero swap count
    do_reset();
    swap_count = 9'd0;
    for (int i = 0; i < 3; i++) begin
      slot(1'b1, 1'b1);
      chk("R2 every BS is SR", sym_code, 2);
    end

    // R3: interval 0 acts as 1
    do_reset();
    swap_count = 9'h1FF;
    idle_interval = 16'd0;
    slot(1'b0, 1'b0);
    chk("R3 interval0 first", sym_code, 1);
    slot(1'b0, 1'b0);
    chk("R3 interval0 second", sym_code, 1);
    idle_interval = 16'd3;

    // R1: full 0x1FF count
    do_reset();
    swap_count = 9'h1FF;
    for (int i = 1; i <= 512; i++) begin
      slot(1'b1, 1'b1);
      if (i == 511) chk("R1 511th is BS", sym_code, 1);
      if (i == 512) chk("R1 512th is SR", sym_code, 2);
    end

    // R5 R6: one-shot with load count 1, swap count 3
    do_reset();
    swap_count = 9'd3;
    load_count = 8'd1;
    pulse_start();
    chk("R5 armed after start", oneshot_armed, 1);
    slot(1'b1, 1'b1);
    chk("R5 first BS", sym_code, 1);
    slot(1'b1, 1'b1);
    chk("R5 forced SR", sym_code, 2);
    chk("R5 disarmed", oneshot_armed, 0);
    slot(1'b1, 1'b1); chk("R6 BS a", sym_code, 1);
    slot(1'b1, 1'b1); chk("R6 BS b", sym_code, 1);
    slot(1'b1, 1'b1); chk("R6 BS c", sym_code, 1);
    slot(1'b1, 1'b1); chk("R6 periodic SR", sym_code, 2);

    // R7: coincident one-shot and periodic
    do_reset();
    swap_count = 9'd2;
    load_count = 8'd2;
    pulse_start();
    slot(1'b1, 1'b1); chk("R7 BS 1", sym_code, 1);
    slot(1'b1, 1'b1); chk("R7 BS 2", sym_code, 1);
    slot(1'b1, 1'b1); chk("R7 single SR", sym_code, 2);
    chk("R7 disarmed", oneshot_armed, 0);
    slot(1'b1, 1'b1); chk("R7 BS 4", sym_code, 1);
    slot(1'b1, 1'b1); chk("R7 BS 5", sym_code, 1);
    slot(1'b1, 1'b1); chk("R7 SR 6", sym_code, 2);

    // R9: back-pressure
    do_reset();
    swap_count = 9'd4;
    sym_ready = 1'b0;
    slot(1'b1, 1'b1);
    chk("R9 first BS", sym_code, 1);
    video_active = 1'b1;
    slot_bs = 1'b1;
    slot_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk("R9 slot_ready low", slot_ready, 0);
      @(negedge clk);
      chk("R9 code held", sym_code, 1);
      chk("R9 valid held", sym_valid, 1);
    end
    sym_ready = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0;
    chk("R9 stalled slots not counted", sym_code, 1);
    slot(1'b1, 1'b1); chk("R9 BS 3", sym_code, 1);
    slot(1'b1, 1'b1); chk("R9 BS 4", sym_code, 1);
    slot(1'b1, 1'b1); chk("R9 SR 5", sym_code, 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule